// File: doc/BRIEF.md
# Random Interval Pulse Timer

This block raises a one-cycle strobe at irregular, pseudo-random spacing. A 128-bit shift-register random source with xor feedback is organized as four 32-bit lanes. Each time the strobe fires, the source steps once. A narrow slice of its newest lane is folded into a bounded range and becomes the next countdown length. The spacing is set by two inputs: a floor (`gap_min`) and a width (`gap_span`). The countdown lengths fall between `gap_min` and `gap_min + gap_span - 1`. With a floor of 1000 and a width of 9001, the events are spread over roughly one to ten thousand cycles.

All outputs are plain status pins, and there is no handshake. The `enable` pin freezes the block without losing state. A synchronous reset reloads a fixed, nonzero seed. The counter is cleared by reset, so the first strobe comes on the first enabled cycle after reset.

Top module: `rand_gap_timer`

## Requirements
- R1: While `rst` is high, and after it is released, the source state is the seed value 1 and the counter and `load_count` are 0. `rand_word` therefore reads 1 until the first step. The first enabled cycle after reset fires `pulse`. The source state never becomes all zero.
- R2: One step of the source works on four 32-bit lanes, where lane 3 is bits 127:96 and lane 0 is bits 31:0. It computes t = lane3 ^ (lane3 << 11), where all shifts are logical. It computes n = lane0 ^ (lane0 >> 19) ^ t ^ (t >> 8). The new state is {bits 95:0, n}. `rand_word` always shows lane 0.
- R3: The source steps only on a clock edge where `pulse` is high. On every other edge, `rand_word` keeps its value.
- R4: When `pulse` fires, the counter and `load_count` are loaded with `gap_min + (rand_word[13:0] mod gap_span)`. This uses the `rand_word` value present before that edge, and the result is always in [gap_min, gap_min+gap_span-1].
- R5: `pulse` is high exactly in the cycles where `enable` is high and the counter is 0. It never stays high for two cycles in a row.
- R6: If a strobe loads a length L, the next strobe comes on the (L+1)-th enabled cycle after it. Cycles with `enable` low are not counted.
- R7: While `enable` is low, `pulse` stays low and the counter, the source state, `rand_word` and `load_count` all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Counting and stepping allowed when high |
| gap_min | input | 16 | Smallest countdown length, at least 1 |
| gap_span | input | 14 | Number of distinct lengths, at least 1 |
| pulse | output | 1 | One-cycle timing event |
| rand_word | output | 32 | Newest 32-bit lane of the random source |
| load_count | output | 16 | Countdown length loaded at the latest event |

## Verification
The properties assume that `gap_min` and `gap_span` are both at least 1 and that `gap_min + gap_span - 1` fits in 16 bits. They also assume that both inputs stay steady through any cycle that fires and the cycle after it. The stimulus holds the range inputs fixed for a whole run and changes them only while reset is high. It uses floor and width pairs inside those bounds, including the degenerate width of 1. It toggles `enable` at random at several duty levels, so the hold and gap-counting rules are exercised across idle stretches.

// File: rtl/rgt_pkg.sv
package rgt_pkg;
  localparam int LANE_W_DEF  = 32;
  localparam int LANES_DEF   = 4;
  localparam int SLICE_W_DEF = 14;
  localparam int CNT_W_DEF   = 16;
  localparam int MIX_SHL_DEF = 11;
  localparam int MIX_SHR_LO  = 19;
  localparam int MIX_SHR_T   = 8;
endpackage

// File: rtl/rgt_xorshift.sv
module rgt_xorshift #(
  parameter int LANE_W  = rgt_pkg::LANE_W_DEF,
  parameter int LANES   = rgt_pkg::LANES_DEF,
  parameter int SHL_T   = rgt_pkg::MIX_SHL_DEF,
  parameter int SHR_LO  = rgt_pkg::MIX_SHR_LO,
  parameter int SHR_T   = rgt_pkg::MIX_SHR_T,
  parameter logic [LANE_W*LANES-1:0] SEED = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  output logic [LANE_W*LANES-1:0] state_o,
  output logic [LANE_W-1:0]       lane0_o
);
  localparam int STATE_W = LANE_W * LANES;

  logic [STATE_W-1:0] st_q;
  logic [LANE_W-1:0]  top_lane, low_lane, mix_t, fresh;

  // mix the oldest lane with a left shift, then fold in the newest lane
  assign top_lane = st_q[STATE_W-1 -: LANE_W];
  assign low_lane = st_q[LANE_W-1:0];
  assign mix_t    = top_lane ^ (top_lane << SHL_T);
  assign fresh    = low_lane ^ (low_lane >> SHR_LO) ^ mix_t ^ (mix_t >> SHR_T);

  always_ff @(posedge clk) begin
    if (rst)       st_q <= SEED;
    else if (step) st_q <= {st_q[STATE_W-LANE_W-1:0], fresh};
  end

  assign state_o = st_q;
  assign lane0_o = low_lane;
endmodule

// File: rtl/rgt_reduce.sv
module rgt_reduce #(
  parameter int SLICE_W = rgt_pkg::SLICE_W_DEF,
  parameter int CNT_W   = rgt_pkg::CNT_W_DEF
) (
  input  logic [SLICE_W-1:0] raw,
  input  logic [SLICE_W-1:0] span,
  input  logic [CNT_W-1:0]   base,
  output logic [CNT_W-1:0]   reload
);
  localparam int TRIAL_W = SLICE_W + 1;

  // restoring remainder: one compare-subtract stage per slice bit, MSB first
  logic [SLICE_W-1:0] rem [0:SLICE_W];
  logic [TRIAL_W-1:0] span_x;

  assign span_x       = {1'b0, span};
  assign rem[SLICE_W] = '0;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_stage
    logic [TRIAL_W-1:0] trial;
    logic [TRIAL_W-1:0] kept;
    assign trial  = {rem[i+1], raw[i]};
    assign kept   = (trial >= span_x) ? (trial - span_x) : trial;
    assign rem[i] = kept[SLICE_W-1:0];
  end

  assign reload = base + CNT_W'(rem[0]);
endmodule

// File: rtl/rgt_countdown.sv
module rgt_countdown #(
  parameter int CNT_W = rgt_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] reload_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] load_o
);
  logic [CNT_W-1:0] cnt_q, load_q;

  assign fire_o = enable && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else if (fire_o) begin
      cnt_q  <= reload_i;
      load_q <= reload_i;
    end else if (enable) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign load_o = load_q;
endmodule

// File: rtl/rand_gap_timer.sv
module rand_gap_timer #(
  parameter int LANE_W  = rgt_pkg::LANE_W_DEF,
  parameter int LANES   = rgt_pkg::LANES_DEF,
  parameter int SLICE_W = rgt_pkg::SLICE_W_DEF,
  parameter int CNT_W   = rgt_pkg::CNT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [CNT_W-1:0]   gap_min,
  input  logic [SLICE_W-1:0] gap_span,
  output logic               pulse,
  output logic [LANE_W-1:0]  rand_word,
  output logic [CNT_W-1:0]   load_count
);
  localparam int STATE_W = LANE_W * LANES;

  logic               fire;
  logic [STATE_W-1:0] gen_state;
  logic [CNT_W-1:0]   next_len;

  rgt_xorshift #(.LANE_W(LANE_W), .LANES(LANES)) u_gen (
    .clk(clk), .rst(rst), .step(fire),
    .state_o(gen_state), .lane0_o(rand_word)
  );

  rgt_reduce #(.SLICE_W(SLICE_W), .CNT_W(CNT_W)) u_fold (
    .raw(rand_word[SLICE_W-1:0]), .span(gap_span),
    .base(gap_min), .reload(next_len)
  );

  rgt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable),
    .reload_i(next_len), .fire_o(fire), .load_o(load_count)
  );

  assign pulse = fire;
endmodule

// File: rtl/rand_gap_timer_chk.sv
module rand_gap_timer_chk #(
  parameter int LANE_W  = 32,
  parameter int LANES   = 4,
  parameter int SLICE_W = 14,
  parameter int CNT_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic [CNT_W-1:0]        gap_min,
  input logic [SLICE_W-1:0]      gap_span,
  input logic                    pulse,
  input logic [LANE_W-1:0]       rand_word,
  input logic [CNT_W-1:0]        load_count,
  input logic [LANE_W*LANES-1:0] gen_state
);
  AST_STATE_LIVE: assert property (@(posedge clk) disable iff (rst) gen_state != '0); // R1
  AST_WORD_QUIET: assert property (@(posedge clk) disable iff (rst) (enable && !pulse) |=> $stable(rand_word)); // R3
  AST_LOAD_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    pulse |=> (load_count >= $past(gap_min)) &&
              ((load_count - $past(gap_min)) < CNT_W'($past(gap_span)))); // R4
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) pulse |=> !pulse); // R5
  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (rst) pulse |-> enable); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(rand_word) && $stable(load_count) && $stable(gen_state)); // R7
endmodule

bind rand_gap_timer rand_gap_timer_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .SLICE_W(SLICE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .gap_min(gap_min), .gap_span(gap_span),
  .pulse(pulse), .rand_word(rand_word), .load_count(load_count), .gen_state(gen_state)
);

// File: tb/rand_gap_timer_test.sv
`timescale 1ns/1ps
module rand_gap_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] gap_min = 16'd1;
  logic [13:0] gap_span = 14'd1;
  logic        pulse;
  logic [31:0] rand_word;
  logic [15:0] load_count;

  rand_gap_timer uut (
    .clk(clk), .rst(rst), .enable(enable), .gap_min(gap_min), .gap_span(gap_span),
    .pulse(pulse), .rand_word(rand_word), .load_count(load_count)
  );

  always #2.5 clk = ~clk;

  typedef struct packed { logic [31:0] word; logic [15:0] len; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [127:0] model_step(input logic [127:0] s);
    logic [31:0] t, n;
    t = s[127:96] ^ (s[127:96] << 11);
    n = s[31:0] ^ (s[31:0] >> 19) ^ t ^ (t >> 8);
    return {s[95:0], n};
  endfunction

  // driver: resets, queues the expected events, then runs enable
  task automatic run_phase(input int mn, input int sp, input int n, input int idle_pct);
    logic [127:0] m;
    rst = 1'b1; enable = 1'b0;
    gap_min = 16'(mn); gap_span = 14'(sp);
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(rand_word == 32'd1, "R1", "word in reset", rand_word, 1);
    check(load_count == 16'd0, "R1", "load in reset", load_count, 0);
    m = 128'd1;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({m[31:0], 16'(mn + int'(m[13:0]) % sp)});
      m = model_step(m);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    while (exp_q.size() > 0) begin
      @(posedge clk); #1;
      enable = ($urandom_range(99) >= idle_pct);
    end
    @(posedge clk); #1;
    enable = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // monitor: pops expected events as pulses appear
  bit          first_evt = 1'b1;
  bit          was_idle = 1'b0;
  bit          len_due = 1'b0;
  int          gap = 0;
  logic [15:0] last_len = '0;
  logic [15:0] due_len = '0;
  logic [31:0] prev_word = '0;
  logic [15:0] prev_load = '0;

  always @(negedge clk) begin
    if (rst) begin
      first_evt = 1'b1; was_idle = 1'b0; len_due = 1'b0; gap = 0;
    end else begin
      if (len_due) begin
        check(load_count == due_len, "R4", "loaded length", load_count, due_len);
        check(!pulse, "R5", "pulse after event", pulse, 0);
        len_due = 1'b0;
      end
      if (was_idle) begin
        check(rand_word == prev_word, "R7", "word held while idle", rand_word, prev_word);
        check(load_count == prev_load, "R7", "load held while idle", load_count, prev_load);
      end
      if (!enable) begin
        check(!pulse, "R7", "pulse while idle", pulse, 0);
      end else if (pulse) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rand_word == e.word, "R2", "word at event", rand_word, e.word);
          check(e.len >= gap_min && e.len < gap_min + 16'(gap_span), "R4",
                "length in range", e.len, gap_min);
          if (!first_evt)
            check(gap == int'(last_len), "R6", "enabled cycles between events", gap, last_len);
          last_len = e.len; due_len = e.len; len_due = 1'b1;
        end
        first_evt = 1'b0;
        gap = 0;
      end else begin
        if (first_evt) check(1'b0, "R1", "no pulse on first enabled cycle", 0, 1);
        first_evt = 1'b0;
        gap++;
        if (int'(gap) > int'(last_len))
          check(1'b0, "R3", "counter overran length", gap, last_len);
      end
      was_idle  = !enable;
      prev_word = rand_word;
      prev_load = load_count;
    end
  end

  initial begin
    run_phase(1000, 9001, 4, 0);
    run_phase(3, 5, 60, 30);
    run_phase(1, 1, 40, 0);
    run_phase(200, 300, 10, 50);
    run_phase(7, 16383, 3, 20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule